// File: doc/BRIEF.md
# Program Busy Status Read Responder

This block sits on the read data path of a flash-style memory model. While a program cycle is in progress, it replaces the word read from the array with status information. A host can then see that the program cycle has finished by either of two methods. The first is polling: the top bit of each byte reads back as the inverse of the last word loaded, so the true value shows up once the cycle is over. The second is toggle checking: one designated bit of each byte changes value on every new read access, and it stops changing when the cycle ends.

A read access is active while both the chip-select and output-enable inputs are high. A new access begins on the clock edge at which that combined read strobe is first sampled high after having been sampled low. A new access can therefore start from either enable. One flip-flop holds the toggle state, and the toggle bit of every byte lane shares it. The output word is combinational in the busy flag, the last loaded word, the array data and the toggle state. Status is therefore visible in the same cycle that the busy flag rises.

Top module: `program_busy_read_responder`

## Requirements
- R1: While reset is asserted, the toggle state is 0. So with `prog_busy` high during reset, bits 6 and 14 of `rd_word` read 0.
- R2: While `prog_busy` is high, bit 7 and bit 15 of `rd_word` equal the inverse of bit 7 and bit 15 of `last_load`.
- R3: While `prog_busy` is high, bits 6 and 14 of `rd_word` invert after each clock edge at which a new read access starts. A new access starts at an edge where (`cs_act` AND `oe_act`) is sampled 1 and was sampled 0 at the previous edge; the previous-edge sample is 0 after reset.
- R4: While `prog_busy` is low, `rd_word` equals `array_rdata` on all 16 bits.
- R5: A read access that starts while `prog_busy` is low does not advance the toggle state. Bits 6 and 14 in the next busy period resume from the value they last showed.
- R6: A read strobe held high across several edges counts as one access. Bits 6 and 14 stay stable while the strobe stays high.
- R7: While `prog_busy` is high, every bit other than 6, 7, 14 and 15 of `rd_word` equals the same bit of `last_load`.
- R8: Status appears in the same cycle that `prog_busy` rises, with no added clock of latency.
- R9: A new access counts whether it is started by raising `oe_act` while `cs_act` is held high, or by raising `cs_act` while `oe_act` is held high.
- R10: While `prog_busy` is high, bit 6 and bit 14 of `rd_word` are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_act | input | 1 | Chip select, active high |
| oe_act | input | 1 | Output enable, active high |
| prog_busy | input | 1 | High while a program cycle runs |
| last_load | input | 16 | Last data word loaded before programming |
| array_rdata | input | 16 | Word read from the storage array |
| rd_word | output | 16 | Read word returned to the host |

## Verification
The bench builds the block with its default parameters: a 16-bit word of two 8-bit lanes, polling on lane bit 7, toggling on lane bit 6, and both methods enabled. This setting reaches both lane copies of every status bit. It also reaches the shared toggle flip-flop, the two ways of starting an access, held strobes, idle accesses, and status reads that start in the very cycle that busy rises. A free-running behavioural model predicts the word on every clock. Directed sequences then target the access-start corner cases.

// File: rtl/srr_pkg.sv
package srr_pkg;

   typedef enum logic [1:0] {
      SRR_ROLE_DATA   = 2'd0,
      SRR_ROLE_POLL   = 2'd1,
      SRR_ROLE_TOGGLE = 2'd2
   } srr_role_e;

   // Role of a bit, from its position inside a byte lane
   function automatic srr_role_e srr_role_of(input int unsigned pos,
                                             input int unsigned poll_pos,
                                             input int unsigned tog_pos,
                                             input bit poll_en,
                                             input bit tog_en);
      if (poll_en && pos == poll_pos) return SRR_ROLE_POLL;
      if (tog_en && pos == tog_pos)   return SRR_ROLE_TOGGLE;
      return SRR_ROLE_DATA;
   endfunction

endpackage

// File: rtl/srr_access_detect.sv
module srr_access_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_act,
   input  logic oe_act,
   output logic acc_start
);
   logic strobe;
   logic strobe_q;

   assign strobe = cs_act & oe_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q <= 1'b0;
      else        strobe_q <= strobe;
   end

   assign acc_start = strobe & ~strobe_q;
endmodule

// File: rtl/srr_toggle_state.sv
module srr_toggle_state #(
   parameter bit TOG_INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic advance,
   output logic tog
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tog <= TOG_INIT;
      else if (advance) tog <= ~tog;
   end
endmodule

// File: rtl/srr_status_compose.sv
module srr_status_compose
   import srr_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned LANE_W   = 8,
   parameter int unsigned POLL_POS = 7,
   parameter int unsigned TOG_POS  = 6,
   parameter bit          POLL_EN  = 1'b1,
   parameter bit          TOG_EN   = 1'b1
) (
   input  logic              busy,
   input  logic              tog,
   input  logic [DATA_W-1:0] last_word,
   input  logic [DATA_W-1:0] arr_word,
   output logic [DATA_W-1:0] out_word
);
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam int unsigned POS = b % LANE_W;
      localparam srr_role_e ROLE = srr_role_of(POS, POLL_POS, TOG_POS, POLL_EN, TOG_EN);
      if (ROLE == SRR_ROLE_POLL) begin : g_poll
         assign out_word[b] = busy ? ~last_word[b] : arr_word[b];
      end else if (ROLE == SRR_ROLE_TOGGLE) begin : g_tog
         assign out_word[b] = busy ? tog : arr_word[b];
      end else begin : g_data
         assign out_word[b] = busy ? last_word[b] : arr_word[b];
      end
   end
endmodule

// File: rtl/program_busy_read_responder.sv
module program_busy_read_responder #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned LANE_W   = 8,
   parameter int unsigned POLL_POS = 7,
   parameter int unsigned TOG_POS  = 6,
   parameter bit          POLL_EN  = 1'b1,
   parameter bit          TOG_EN   = 1'b1,
   parameter bit          TOG_INIT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              oe_act,
   input  logic              prog_busy,
   input  logic [DATA_W-1:0] last_load,
   input  logic [DATA_W-1:0] array_rdata,
   output logic [DATA_W-1:0] rd_word
);
   localparam int unsigned NLANE = DATA_W / LANE_W;

   // elaboration-time parameter checks
   if (DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("DATA_W must be a multiple of LANE_W");
   end
   if (POLL_POS >= LANE_W || TOG_POS >= LANE_W) begin : g_bad_pos
      $error("status bit positions must lie inside a lane");
   end
   if (POLL_EN && TOG_EN && POLL_POS == TOG_POS) begin : g_bad_overlap
      $error("polling and toggle bits must differ");
   end

   logic acc_start;
   logic tog;

   srr_access_detect u_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_act    (cs_act),
      .oe_act    (oe_act),
      .acc_start (acc_start)
   );

   if (TOG_EN) begin : g_toggle
      srr_toggle_state #(.TOG_INIT(TOG_INIT)) u_tog (
         .clk     (clk),
         .rst_n   (rst_n),
         .advance (acc_start & prog_busy),
         .tog     (tog)
      );
   end else begin : g_no_toggle
      assign tog = TOG_INIT;
   end

   srr_status_compose #(
      .DATA_W   (DATA_W),
      .LANE_W   (LANE_W),
      .POLL_POS (POLL_POS),
      .TOG_POS  (TOG_POS),
      .POLL_EN  (POLL_EN),
      .TOG_EN   (TOG_EN)
   ) u_compose (
      .busy      (prog_busy),
      .tog       (tog),
      .last_word (last_load),
      .arr_word  (array_rdata),
      .out_word  (rd_word)
   );

   // ---------------- assertions ----------------
   assert_idle_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_busy |-> rd_word == array_rdata);

   for (genvar l = 0; l < NLANE; l++) begin : g_lane_chk
      localparam int unsigned PB = l * LANE_W + POLL_POS;
      localparam int unsigned TB = l * LANE_W + TOG_POS;
      if (POLL_EN) begin : g_poll_chk
         assert_poll_inv_R2: assert property (@(posedge clk) disable iff (!rst_n)
            prog_busy |-> rd_word[PB] == ~last_load[PB]);
      end
      if (TOG_EN) begin : g_tog_chk
         assert_tog_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (prog_busy && acc_start) |=> (prog_busy |-> rd_word[TB] != $past(rd_word[TB])));
         assert_tog_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (prog_busy && !acc_start) |=> (prog_busy |-> $stable(rd_word[TB])));
         assert_tog_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
            prog_busy |-> rd_word[TB] == rd_word[TOG_POS]);
      end
   end
endmodule

// File: tb/test_program_busy_read_responder.sv
`timescale 1ns/1ps
module test_program_busy_read_responder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_act = 1'b0;
   logic        oe_act = 1'b0;
   logic        prog_busy = 1'b1;
   logic [15:0] last_load = 16'hA5C3;
   logic [15:0] array_rdata = 16'h0F0F;
   logic [15:0] rd_word;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   program_busy_read_responder i_program_busy_read_responder (
      .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .oe_act(oe_act),
      .prog_busy(prog_busy), .last_load(last_load),
      .array_rdata(array_rdata), .rd_word(rd_word));

   always #2 clk = ~clk;   // 250 MHz

   // behavioural reference: toggle state and previous strobe sample
   bit m_tog;
   bit m_prev;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_tog  <= 1'b0;
         m_prev <= 1'b0;
      end else begin
         if (prog_busy && cs_act && oe_act && !m_prev) m_tog <= ~m_tog;
         m_prev <= cs_act && oe_act;
      end
   end

   function automatic logic [15:0] model_word();
      logic [15:0] w;
      for (int b = 0; b < 16; b++) begin
         if (!prog_busy)      w[b] = array_rdata[b];
         else if (b % 8 == 7) w[b] = ~last_load[b];
         else if (b % 8 == 6) w[b] = m_tog;
         else                 w[b] = last_load[b];
      end
      return w;
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model, split by field
   always @(negedge clk) begin
      logic [15:0] e;
      e = model_word();
      if (prog_busy) begin
         chk("R2 poll bits", rd_word & 16'h8080, e & 16'h8080);
         chk("R3 toggle bits", rd_word & 16'h4040, e & 16'h4040);
         chk("R7 data bits", rd_word & 16'h3F3F, e & 16'h3F3F);
      end else begin
         chk("R4 idle passthrough", rd_word, e);
      end
   end

   task automatic cyc(input int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      logic v0;
      void'($urandom(32'h5EED));
      // R1: reset value of toggle state
      cyc(3);
      #0.5;
      chk("R1 reset toggle", rd_word & 16'h4040, 16'h0000);
      rst_n = 1'b1;
      // R8: busy rising shows status in the same cycle
      prog_busy = 1'b0;
      cyc(2);
      last_load = 16'h1234;
      prog_busy = 1'b1;
      #0.5;
      chk("R8 same-cycle status", rd_word, {~last_load[15], 1'b0, last_load[13:8],
                                            ~last_load[7], 1'b0, last_load[5:0]});
      // R9: access started by output enable
      cs_act = 1'b1; oe_act = 1'b1;
      cyc(2);
      #0.5; v0 = rd_word[6];
      oe_act = 1'b0; cyc();
      oe_act = 1'b1; cyc();
      #0.5;
      chk("R9 oe starts access", {15'd0, rd_word[6]}, {15'd0, ~v0});
      // R9: access started by chip select
      v0 = rd_word[6];
      cs_act = 1'b0; cyc();
      cs_act = 1'b1; cyc();
      #0.5;
      chk("R9 cs starts access", {15'd0, rd_word[6]}, {15'd0, ~v0});
      // R6: held strobe stays one access
      v0 = rd_word[6];
      cyc(5);
      #0.5;
      chk("R6 held strobe stable", {15'd0, rd_word[6]}, {15'd0, v0});
      // R10: both lanes agree
      chk("R10 lane pair", {15'd0, rd_word[14]}, {15'd0, rd_word[6]});
      // R5: three idle accesses do not advance the toggle
      v0 = rd_word[6];
      cs_act = 1'b0; oe_act = 1'b0;
      prog_busy = 1'b0;
      for (int i = 0; i < 3; i++) begin
         cyc(); cs_act = 1'b1; oe_act = 1'b1;
         cyc(); cs_act = 1'b0; oe_act = 1'b0;
      end
      cyc();
      prog_busy = 1'b1;
      #0.5;
      chk("R5 idle access ignored", {15'd0, rd_word[6]}, {15'd0, v0});
      // mixed random traffic, checked every clock by the model (R2 R3 R4 R7)
      for (int i = 0; i < 2000; i++) begin
         cyc();
         cs_act = ($urandom % 4) != 0;
         oe_act = $urandom % 2;
         if ($urandom % 16 == 0) prog_busy = ~prog_busy;
         if ($urandom % 8 == 0) last_load = 16'($urandom);
         array_rdata = 16'($urandom);
      end
      // R4: after the cycle ends, true data on all bits
      prog_busy = 1'b0;
      array_rdata = 16'hC0DE;
      #0.5;
      chk("R4 true data after busy", rd_word, 16'hC0DE);
      cyc(2);
      done = 1'b1;
      finish_run();
   end
endmodule